// File: doc/BRIEF.md
# Four-Beat Wide Search Request Capture

This block receives a 272-bit search request from a host command bus. The request spans four consecutive clock cycles called beats A, B, C and D. Each beat carries 68 bits of key data on the data bus, together with a 9-bit side-band command word. The block checks that every beat is a search beat. It gathers the four data slices into one key and samples the side-band fields that belong to particular beats. It then presents the whole request downstream with a one-cycle completion strobe. The downstream stages are the mask lookup, the table compare and the result-address timing.

The control is a four-state machine. `ST_A` waits for the first beat, and `ST_B`, `ST_C` and `ST_D` expect the beats of the same names. The machine has three kinds of transition:

- **take**: a valid beat moves to the next state and loads that beat's slice and fields.
- **finish**: the take out of `ST_D`. It goes back to `ST_A` and issues the completion strobe.
- **abort**: a bad beat in `ST_B`, `ST_C` or `ST_D`. It drops the partial request, raises a one-cycle error pulse and goes back to `ST_A`.

In `ST_A`, a cycle that is not a search beat is simply idle bus and is ignored.

Top module: `wsrch_capture`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done_o` and `err_o` are 0, all field and key outputs are 0, and the block is waiting for beat A.
- R2: A search beat is one with `cmd_vld_i`=1 and `cmd_i[1:0]`=2'b10. In a completed request, beat A's data lands in `key_o[271:204]`, beat B's in `[203:136]`, beat C's in `[135:68]` and beat D's in `[67:0]`.
- R3: `cmd_i[5:3]` sampled on beat A appears on `mask_ab_o`, and `cmd_i[5:3]` sampled on beat C appears on `mask_cd_o`.
- R4: `cmd_i[8:7]` sampled on beat C appears on `addr_hi_o`.
- R5: `cmd_i[8:6]` sampled on beat D appears on `rsl_idx_o`. `cmd_i[5:2]` on beat D has no effect on any output.
- R6: `done_o` is high for exactly one cycle, in the cycle after the clock edge that samples a valid beat D.
- R7: A beat in `ST_B`, `ST_C` or `ST_D` that is not a search beat aborts the request. `err_o` is then high for one cycle after that edge, and the block waits for a new beat A. The aborting beat is never taken as a new beat A.
- R8: On beat C, `cmd_i[2]`=1 is malformed and aborts exactly as in R7, even when the beat is otherwise a search beat.
- R9: The key and field outputs change only together with `done_o`. After an abort they keep the values of the last completed request.
- R10: While waiting for beat A, cycles that are not search beats raise neither `err_o` nor `done_o`.
- R11: A new beat A may directly follow beat D, so back-to-back requests complete once every four cycles and `done_o` is never high in two consecutive cycles.
- R12: `done_o` and `err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_vld_i | input | 1 | Command word valid |
| cmd_i | input | 9 | Side-band command word; [1:0] opcode, others per beat |
| dq_i | input | 68 | Key data slice of the current beat |
| key_o | output | 272 | Assembled search key of the last completed request |
| mask_ab_o | output | 3 | Mask-pair index for key slices A and B |
| mask_cd_o | output | 3 | Mask-pair index for key slices C and D |
| addr_hi_o | output | 2 | Upper result-address bits to use on a hit |
| rsl_idx_o | output | 3 | Result-register index (one of eight) |
| done_o | output | 1 | One-cycle strobe: new request on the outputs |
| err_o | output | 1 | One-cycle strobe: partial request aborted |

## Verification
Every result of this block sits exactly one register behind the beat that causes it:

- `done_o`, the key and all four fields appear in the cycle after the edge that samples beat D.
- `err_o` appears in the cycle after the edge that samples the offending beat.

The bench applies each beat at a falling edge and, in the same step, advances a transaction-level expectation of the request. It compares every output at the next falling edge, half a period after the sampling edge. In cycles without a completion, the key and field checks confirm that the held values are unchanged.

// File: rtl/wsrch_pkg.sv
package wsrch_pkg;
    // beats per wide search request
    localparam int BEATS = 4;
    // opcode value that marks a search beat
    localparam logic [1:0] OP_SEARCH = 2'b10;
    // side-band field geometry (decoded by neighbours, so fixed)
    localparam int CMD_W  = 9;
    localparam int IDX_W  = 3;
    localparam int AHI_W  = 2;
    localparam int SB_LSB = 3;            // lowest command bit passed to field logic
    localparam int SB_W   = CMD_W - SB_LSB;

    typedef enum logic [1:0] {
        ST_A = 2'd0,
        ST_B = 2'd1,
        ST_C = 2'd2,
        ST_D = 2'd3
    } wsrch_state_e;
endpackage

// File: rtl/wsrch_fsm.sv
module wsrch_fsm
    import wsrch_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_vld,
    input  logic [1:0]       op,
    input  logic             c_rsv,
    output logic [BEATS-1:0] ld_o,
    output logic             done_o,
    output logic             err_o
);
    wsrch_state_e state_q, state_n;
    logic         beat_ok;
    logic         abort;

    assign beat_ok = cmd_vld && (op == OP_SEARCH);

    always_comb begin
        state_n = state_q;
        ld_o    = '0;
        abort   = 1'b0;
        unique case (state_q)
            ST_A: begin
                if (beat_ok) begin
                    ld_o[0] = 1'b1;
                    state_n = ST_B;
                end
            end
            ST_B: begin
                if (beat_ok) begin
                    ld_o[1] = 1'b1;
                    state_n = ST_C;
                end else begin
                    abort   = 1'b1;
                    state_n = ST_A;
                end
            end
            ST_C: begin
                if (beat_ok && !c_rsv) begin
                    ld_o[2] = 1'b1;
                    state_n = ST_D;
                end else begin
                    abort   = 1'b1;
                    state_n = ST_A;
                end
            end
            ST_D: begin
                state_n = ST_A;
                if (beat_ok) begin
                    ld_o[3] = 1'b1;
                end else begin
                    abort   = 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_A;
        else        state_q <= state_n;
    end

    // strobe outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= ld_o[BEATS-1];
            err_o  <= abort;
        end
    end

    p_done_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(state_q) == ST_D));

    p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (state_q == ST_A));

    p_c_rsv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_C && c_rsv) |=> err_o);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_A) |=> !err_o);

    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/wsrch_beat_store.sv
module wsrch_beat_store
    import wsrch_pkg::*;
#(
    parameter int BEAT_W = 68,
    localparam int KEY_W = BEAT_W * BEATS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BEATS-1:0]  ld,
    input  logic [BEAT_W-1:0] dq,
    output logic [KEY_W-1:0]  key_o
);
    logic [BEAT_W-1:0] slice_q [BEATS-1];
    logic [KEY_W-1:0]  key_n;

    // earlier beats are parked until the last beat arrives
    for (genvar g = 0; g < BEATS - 1; g++) begin : g_park
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     slice_q[g] <= '0;
            else if (ld[g]) slice_q[g] <= dq;
        end
        assign key_n[KEY_W-1-g*BEAT_W -: BEAT_W] = slice_q[g];
    end
    assign key_n[BEAT_W-1:0] = dq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           key_o <= '0;
        else if (ld[BEATS-1]) key_o <= key_n;
    end
endmodule

// File: rtl/wsrch_fields.sv
module wsrch_fields
    import wsrch_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_a,
    input  logic             ld_c,
    input  logic             ld_d,
    input  logic [SB_W-1:0]  sb,        // command bits [8:3]
    output logic [IDX_W-1:0] mask_ab_o,
    output logic [IDX_W-1:0] mask_cd_o,
    output logic [AHI_W-1:0] addr_hi_o,
    output logic [IDX_W-1:0] rsl_idx_o
);
    logic [IDX_W-1:0] mab_q, mcd_q;
    logic [AHI_W-1:0] ahi_q;

    // pending values, sampled on their own beats
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mab_q <= '0;
            mcd_q <= '0;
            ahi_q <= '0;
        end else begin
            if (ld_a) mab_q <= sb[IDX_W-1:0];
            if (ld_c) begin
                mcd_q <= sb[IDX_W-1:0];
                ahi_q <= sb[SB_W-1 -: AHI_W];
            end
        end
    end

    // published together on the final beat
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_ab_o <= '0;
            mask_cd_o <= '0;
            addr_hi_o <= '0;
            rsl_idx_o <= '0;
        end else if (ld_d) begin
            mask_ab_o <= mab_q;
            mask_cd_o <= mcd_q;
            addr_hi_o <= ahi_q;
            rsl_idx_o <= sb[SB_W-1 -: IDX_W];
        end
    end
endmodule

// File: rtl/wsrch_capture.sv
module wsrch_capture
    import wsrch_pkg::*;
#(
    parameter int BEAT_W = 68,
    localparam int KEY_W = BEAT_W * BEATS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [BEAT_W-1:0] dq_i,
    output logic [KEY_W-1:0]  key_o,
    output logic [IDX_W-1:0]  mask_ab_o,
    output logic [IDX_W-1:0]  mask_cd_o,
    output logic [AHI_W-1:0]  addr_hi_o,
    output logic [IDX_W-1:0]  rsl_idx_o,
    output logic              done_o,
    output logic              err_o
);
    logic [BEATS-1:0] ld;

    wsrch_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_vld (cmd_vld_i),
        .op      (cmd_i[1:0]),
        .c_rsv   (cmd_i[2]),
        .ld_o    (ld),
        .done_o  (done_o),
        .err_o   (err_o)
    );

    wsrch_beat_store #(.BEAT_W(BEAT_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld),
        .dq    (dq_i),
        .key_o (key_o)
    );

    wsrch_fields u_fields (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_a      (ld[0]),
        .ld_c      (ld[2]),
        .ld_d      (ld[BEATS-1]),
        .sb        (cmd_i[CMD_W-1:SB_LSB]),
        .mask_ab_o (mask_ab_o),
        .mask_cd_o (mask_cd_o),
        .addr_hi_o (addr_hi_o),
        .rsl_idx_o (rsl_idx_o)
    );

    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    p_hold_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(key_o));

    p_hold_fld_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(mask_ab_o) && $stable(mask_cd_o)
                     && $stable(addr_hi_o) && $stable(rsl_idx_o)));
endmodule

// File: tb/test_wsrch_capture.sv
`timescale 1ns/1ps
module test_wsrch_capture;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_vld = 1'b0;
    logic [8:0]   cmd = '0;
    logic [67:0]  dq = '0;
    logic [271:0] key_o;
    logic [2:0]   mask_ab_o, mask_cd_o, rsl_idx_o;
    logic [1:0]   addr_hi_o;
    logic         done_o, err_o;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    wsrch_capture i_wsrch_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_vld_i (cmd_vld),
        .cmd_i     (cmd),
        .dq_i      (dq),
        .key_o     (key_o),
        .mask_ab_o (mask_ab_o),
        .mask_cd_o (mask_cd_o),
        .addr_hi_o (addr_hi_o),
        .rsl_idx_o (rsl_idx_o),
        .done_o    (done_o),
        .err_o     (err_o)
    );

    // transaction-level expectation
    int           m_st = 0;
    logic [67:0]  m_a, m_b, m_c;
    logic [2:0]   m_mab, m_mcd;
    logic [1:0]   m_ah;
    logic [271:0] e_key = '0;
    logic [2:0]   e_mab = '0, e_mcd = '0, e_idx = '0;
    logic [1:0]   e_ah = '0;
    logic         e_done = 1'b0, e_err = 1'b0;

    function automatic logic [67:0] rnd68();
        return {$urandom(), $urandom(), $urandom()};
    endfunction

    function automatic logic [1:0] bad_op();
        int k = $urandom_range(2, 0);
        return (k == 0) ? 2'b00 : (k == 1) ? 2'b01 : 2'b11;
    endfunction

    task automatic chk(input bit ok, input string tag, input string scen,
                       input logic [271:0] act, input logic [271:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (%s): actual %h expected %h", tag, scen, act, exp);
        end
    endtask

    task automatic model(input logic v, input logic [8:0] c, input logic [67:0] d);
        bit good = v && (c[1:0] == 2'b10);
        e_done = 1'b0;
        e_err  = 1'b0;
        case (m_st)
            0: if (good) begin m_a = d; m_mab = c[5:3]; m_st = 1; end
            1: if (good) begin m_b = d; m_st = 2; end
               else begin e_err = 1'b1; m_st = 0; end
            2: if (good && !c[2]) begin
                   m_c = d; m_mcd = c[5:3]; m_ah = c[8:7]; m_st = 3;
               end else begin e_err = 1'b1; m_st = 0; end
            default: begin
                if (good) begin
                    e_key = {m_a, m_b, m_c, d};
                    e_mab = m_mab; e_mcd = m_mcd; e_ah = m_ah; e_idx = c[8:6];
                    e_done = 1'b1;
                end else e_err = 1'b1;
                m_st = 0;
            end
        endcase
    endtask

    // drive one cycle at a falling edge, check at the next falling edge
    task automatic step(input logic v, input logic [8:0] c, input logic [67:0] d,
                        input string scen);
        string ft;
        cmd_vld = v; cmd = c; dq = d;
        model(v, c, d);
        @(negedge clk);
        chk(done_o == e_done, e_done ? "R6" : "R11", scen, 272'(done_o), 272'(e_done));
        chk(err_o == e_err, e_err ? "R7" : "R10", scen, 272'(err_o), 272'(e_err));
        chk(!(done_o && err_o), "R12", scen, {done_o, err_o}, 272'(0));
        ft = e_done ? "R2" : "R9";
        chk(key_o == e_key, ft, scen, key_o, e_key);
        ft = e_done ? "R3" : "R9";
        chk({mask_ab_o, mask_cd_o} == {e_mab, e_mcd}, ft, scen,
            272'({mask_ab_o, mask_cd_o}), 272'({e_mab, e_mcd}));
        ft = e_done ? "R4" : "R9";
        chk(addr_hi_o == e_ah, ft, scen, 272'(addr_hi_o), 272'(e_ah));
        ft = e_done ? "R5" : "R9";
        chk(rsl_idx_o == e_idx, ft, scen, 272'(rsl_idx_o), 272'(e_idx));
    endtask

    task automatic idle(input string scen);
        step(1'b0, 9'(bad_op()), rnd68(), scen);
    endtask

    // full request; bad_beat 1..3 corrupts that beat (0 = clean),
    // how: 0 valid low, 1 wrong opcode, 2 reserved bit on beat C
    task automatic search(input logic [271:0] k, input logic [2:0] mab,
                          input logic [2:0] mcd, input logic [1:0] ah,
                          input logic [2:0] idx, input logic [3:0] ign,
                          input int bad_beat, input int how, input string scen);
        logic [8:0] c [4];
        logic       v [4];
        c[0] = {3'($urandom()), mab, 1'b0, 2'b10};
        c[1] = {6'($urandom()), 1'b0, 2'b10};
        c[2] = {ah, 1'($urandom()), mcd, 1'b0, 2'b10};
        c[3] = {idx, ign, 2'b10};
        for (int i = 0; i < 4; i++) v[i] = 1'b1;
        if (bad_beat > 0) begin
            if (how == 0)                        v[bad_beat] = 1'b0;
            else if (how == 2 && bad_beat == 2)  c[2][2] = 1'b1;
            else                                 c[bad_beat][1:0] = bad_op();
        end
        for (int i = 0; i < 4; i++) begin
            step(v[i], c[i], k[271-68*i -: 68], scen);
            if (bad_beat == i && bad_beat > 0) break;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({done_o, err_o} == 2'b00, "R1", "in reset", 272'({done_o, err_o}), 272'(0));
        chk(key_o == '0, "R1", "in reset", key_o, 272'(0));
        chk({mask_ab_o, mask_cd_o, addr_hi_o, rsl_idx_o} == '0, "R1", "in reset",
            272'({mask_ab_o, mask_cd_o, addr_hi_o, rsl_idx_o}), 272'(0));
        rst_n = 1'b1;
        idle("R1 after reset");

        // directed: slice order R2, fields R3 R4 R5
        search({68'h1_1111_1111_1111_1111, 68'h2_2222_2222_2222_2222,
                68'h3_3333_3333_3333_3333, 68'h4_4444_4444_4444_4444},
               3'd5, 3'd2, 2'b10, 3'd6, 4'h0, 0, 0, "R2 directed");
        idle("R9 idle");
        // R5: beat D low bits set, no effect
        search({4{rnd68()}}, 3'd1, 3'd7, 2'b01, 3'd3, 4'hF, 0, 0, "R5 ignored bits");
        // R7: aborts on each beat, outputs held R9
        search({4{rnd68()}}, 3'd4, 3'd4, 2'b11, 3'd1, 4'h0, 1, 0, "R7 vld low at B");
        search({4{rnd68()}}, 3'd4, 3'd4, 2'b11, 3'd1, 4'h0, 3, 1, "R7 bad op at D");
        // R8: reserved bit on beat C with otherwise valid beat
        search({4{rnd68()}}, 3'd2, 3'd3, 2'b00, 3'd7, 4'h0, 2, 2, "R8 reserved bit");
        // R10: non-search traffic while waiting
        for (int i = 0; i < 6; i++) step(1'b1, {7'($urandom()), bad_op()}, rnd68(), "R10 junk");
        // R11: back-to-back
        for (int i = 0; i < 3; i++)
            search({4{rnd68()}}, 3'($urandom()), 3'($urandom()), 2'($urandom()),
                   3'($urandom()), 4'($urandom()), 0, 0, "R11 back-to-back");

        // constrained random mix
        for (int it = 0; it < 300; it++) begin
            int kind = $urandom_range(7, 0);
            if (kind <= 4)
                search({rnd68(), rnd68(), rnd68(), rnd68()}, 3'($urandom()),
                       3'($urandom()), 2'($urandom()), 3'($urandom()),
                       4'($urandom()), 0, 0, "random R2");
            else if (kind == 5)
                search({rnd68(), rnd68(), rnd68(), rnd68()}, 3'($urandom()),
                       3'($urandom()), 2'($urandom()), 3'($urandom()),
                       4'($urandom()), $urandom_range(3, 1), $urandom_range(2, 0),
                       "random R7");
            else if (kind == 6)
                step(1'($urandom()), {7'($urandom()), bad_op()}, rnd68(), "random R10");
            else
                idle("random idle");
        end
        idle("final");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule